// File: doc/BRIEF.md
# Link Error Capture and Interrupt Register Bank

This block is the error-reporting corner of a packetized serial memory link controller. It watches each response as it leaves the receive path. It checks that the 3-bit sequence tag of every response continues the count from the previous one. It also flags any response whose error-status field is nonzero, and it records the error status and cube identifier of the first such response. Three event sources from elsewhere in the controller also feed the bank: a retry-buffer-full pulse, a response-queue ECC pulse and an active-low fatal pin.

Every source sets a sticky bit in a status register that software clears by writing ones. A per-bit enable register and a single global enable decide whether a set bit drives the one interrupt output. Software reaches the registers through a word-addressed port: it writes in one cycle, and read data returns one cycle after the address is presented.

Top module: `lnk_err_csr`

## Requirements
- R1: Registers are selected by word address: 5 is the error-response register, 8 is status, 9 is enable and 10 is global enable. `csr_rdata` shows the register at `csr_addr` one clock after the address is applied, and any other address reads 0.
- R2: All status bits reset to 0. Writing to word 8 clears every status bit that has a 1 in the write data, and a 0 in the write data leaves that bit unchanged.
- R3: Status bit 0 flags a sequence error. The first response after reset sets the reference. Each later response is expected to carry the previous expected tag plus 1, modulo 8. A mismatch sets bit 0, and the expectation still advances by one.
- R4: Status bit 1 sets when a valid response carries a nonzero error-status field.
- R5: The error-response register holds the error status in bits 6:0 and the cube identifier in bits 10:8. It captures the first error response and keeps that value while status bit 1 stays set.
- R6: When a source event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set. For bit 1 in that case, the new response is also captured.
- R7: Status bit 8 sets on a retry-buffer-full pulse, bit 14 on a response-queue ECC pulse, and bit 13 in any cycle where `fatal_n` is low.
- R8: Only enable bits 0, 1, 8, 13 and 14 can be written. Every other bit of the enable register and of the status register reads 0. Everything resets to 0.
- R9: `irq` is registered. It goes high one clock after a status bit is set with its enable bit set and global enable at 1, and it falls one clock after that condition ends.
- R10: Global enable is bit 0 of word 10. While it is 0, `irq` stays low whatever the status and enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 4 | Word address |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Registered read data |
| rsp_valid | input | 1 | A response is present this cycle |
| rsp_seq | input | 3 | Response sequence tag |
| rsp_errstat | input | 7 | Response error-status field |
| rsp_cub | input | 3 | Response cube identifier |
| ev_retry_full | input | 1 | Retry buffer full pulse |
| ev_rspq_ecc | input | 1 | Response queue ECC error pulse |
| fatal_n | input | 1 | Fatal error pin, active low |
| irq | output | 1 | Interrupt output |

## Verification
A software clear of status bit 1 can land in the same cycle as a new error response. The bench provokes this by asserting a write of 2 to word 8 on the same clock edge as a valid response with a nonzero error status. It then judges the outcome by reading back status bit 1, which must still be set, and the error-response register, which must hold the newly arrived fields. Sequence mismatches are swept across every nonzero tag offset. Each source is also paired with its own enable and with the global enable to observe `irq`.

// File: rtl/lnk_err_pkg.sv
package lnk_err_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned NSRC     = 5;
    localparam int unsigned SRC_SEQ  = 0;
    localparam int unsigned SRC_ERR  = 1;
    localparam int unsigned SRC_RTY  = 2;
    localparam int unsigned SRC_FTL  = 3;
    localparam int unsigned SRC_ECC  = 4;
    localparam int unsigned WA_ERRRSP = 5;
    localparam int unsigned WA_STAT   = 8;
    localparam int unsigned WA_EN     = 9;
    localparam int unsigned WA_GEN    = 10;
    localparam int unsigned CUB_LSB   = 8;

    // status bit position of each source
    function automatic int unsigned src_bit(int unsigned i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 8;
            3:       return 13;
            default: return 14;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/lnk_seq_chk.sv
module lnk_seq_chk #(
    parameter int unsigned SEQ_W     = 3,
    parameter int unsigned ERRSTAT_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rsp_valid,
    input  logic [SEQ_W-1:0]     rsp_seq,
    input  logic [ERRSTAT_W-1:0] rsp_errstat,
    output logic                 seq_err,
    output logic                 err_rsp
);
    typedef struct packed {
        logic             seen;
        logic [SEQ_W-1:0] exp;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        seq_err = rsp_valid && st_q.seen && (rsp_seq != st_q.exp);
        err_rsp = rsp_valid && (|rsp_errstat);
        if (rsp_valid) begin
            st_d.seen = 1'b1;
            st_d.exp  = (st_q.seen ? st_q.exp : rsp_seq) + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lnk_err_cap.sv
module lnk_err_cap #(
    parameter int unsigned ERRSTAT_W = 7,
    parameter int unsigned CUB_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_evt,
    input  logic                 held,
    input  logic                 release_now,
    input  logic [ERRSTAT_W-1:0] errstat,
    input  logic [CUB_W-1:0]     cub,
    output logic [lnk_err_pkg::REG_W-1:0] errrsp_q
);
    import lnk_err_pkg::*;

    logic [REG_W-1:0] errrsp_d;
    logic [REG_W-1:0] fresh;
    logic             capture;

    always_comb begin
        fresh = '0;
        fresh[ERRSTAT_W-1:0]     = errstat;
        fresh[CUB_LSB +: CUB_W]  = cub;
        // a clear in the same cycle frees the register for the newcomer
        capture  = err_evt && (!held || release_now);
        errrsp_d = capture ? fresh : errrsp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) errrsp_q <= '0;
        else        errrsp_q <= errrsp_d;
    end
endmodule

// File: rtl/lnk_irq_ctl.sv
module lnk_irq_ctl #(
    parameter int unsigned NSRC = lnk_err_pkg::NSRC
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               src_evt,
    input  logic [lnk_err_pkg::REG_W-1:0] w1c_mask,
    input  logic                          en_wr,
    input  logic                          gen_wr,
    input  logic [lnk_err_pkg::REG_W-1:0] wdata,
    output logic [lnk_err_pkg::REG_W-1:0] stat_q,
    output logic [lnk_err_pkg::REG_W-1:0] en_q,
    output logic                          gen_q,
    output logic                          irq
);
    import lnk_err_pkg::*;

    localparam logic [REG_W-1:0] MASK = impl_mask();

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
        logic             gen;
        logic             irq;
    } irq_st_t;

    irq_st_t          st_d, st_q;
    logic [REG_W-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        for (int unsigned i = 0; i < NSRC; i++) set_vec[src_bit(i)] = src_evt[i];
    end

    always_comb begin
        st_d      = st_q;
        // set beats clear
        st_d.stat = ((st_q.stat & ~w1c_mask) | set_vec) & MASK;
        if (en_wr)  st_d.en  = wdata & MASK;
        if (gen_wr) st_d.gen = wdata[0];
        st_d.irq  = st_q.gen & (|(st_q.stat & st_q.en));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;
    assign en_q   = st_q.en;
    assign gen_q  = st_q.gen;
    assign irq    = st_q.irq;
endmodule

// File: rtl/lnk_err_csr.sv
module lnk_err_csr #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned SEQ_W     = 3,
    parameter int unsigned ERRSTAT_W = 7,
    parameter int unsigned CUB_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    csr_addr,
    input  logic                 csr_wr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    input  logic                 rsp_valid,
    input  logic [SEQ_W-1:0]     rsp_seq,
    input  logic [ERRSTAT_W-1:0] rsp_errstat,
    input  logic [CUB_W-1:0]     rsp_cub,
    input  logic                 ev_retry_full,
    input  logic                 ev_rspq_ecc,
    input  logic                 fatal_n,
    output logic                 irq
);
    import lnk_err_pkg::*;

    localparam logic [ADDR_W-1:0] A_ERRRSP = ADDR_W'(WA_ERRRSP);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(WA_STAT);
    localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(WA_EN);
    localparam logic [ADDR_W-1:0] A_GEN    = ADDR_W'(WA_GEN);

    logic             seq_err, err_rsp;
    logic [NSRC-1:0]  src_evt;
    logic [REG_W-1:0] w1c_mask;
    logic [REG_W-1:0] stat_q, en_q, errrsp_q;
    logic             gen_q;
    logic             en_wr, gen_wr;
    logic [REG_W-1:0] rdata_d, rdata_q;

    lnk_seq_chk #(.SEQ_W(SEQ_W), .ERRSTAT_W(ERRSTAT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid), .rsp_seq(rsp_seq),
        .rsp_errstat(rsp_errstat), .seq_err(seq_err), .err_rsp(err_rsp)
    );

    always_comb begin
        w1c_mask = (csr_wr && csr_addr == A_STAT) ? csr_wdata : '0;
        en_wr    = csr_wr && csr_addr == A_EN;
        gen_wr   = csr_wr && csr_addr == A_GEN;
        src_evt  = '0;
        src_evt[SRC_SEQ] = seq_err;
        src_evt[SRC_ERR] = err_rsp;
        src_evt[SRC_RTY] = ev_retry_full;
        src_evt[SRC_FTL] = !fatal_n;
        src_evt[SRC_ECC] = ev_rspq_ecc;
    end

    lnk_irq_ctl #(.NSRC(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .w1c_mask(w1c_mask),
        .en_wr(en_wr), .gen_wr(gen_wr), .wdata(csr_wdata),
        .stat_q(stat_q), .en_q(en_q), .gen_q(gen_q), .irq(irq)
    );

    lnk_err_cap #(.ERRSTAT_W(ERRSTAT_W), .CUB_W(CUB_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .err_evt(err_rsp),
        .held(stat_q[src_bit(SRC_ERR)]), .release_now(w1c_mask[src_bit(SRC_ERR)]),
        .errstat(rsp_errstat), .cub(rsp_cub), .errrsp_q(errrsp_q)
    );

    always_comb begin
        if      (csr_addr == A_ERRRSP) rdata_d = errrsp_q;
        else if (csr_addr == A_STAT)   rdata_d = stat_q;
        else if (csr_addr == A_EN)     rdata_d = en_q;
        else if (csr_addr == A_GEN)    rdata_d = {{(REG_W-1){1'b0}}, gen_q};
        else                           rdata_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign csr_rdata = rdata_q;
endmodule

// File: rtl/lnk_err_csr_chk.sv
module lnk_err_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_retry_full,
    input logic        irq,
    input logic        gen_q,
    input logic [31:0] stat_q,
    input logic [31:0] en_q,
    input logic [31:0] w1c_mask,
    input logic [31:0] errrsp_q
);
    // R10
    a_r10_gen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_q |=> !irq);

    // R9
    a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_q && (|(stat_q & en_q))) |=> irq);

    // R2
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~w1c_mask)) == $past(stat_q & ~w1c_mask)));

    // R7
    a_r7_retry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_retry_full |=> stat_q[8]);

    // R5
    a_r5_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[1] && !w1c_mask[1]) |=> $stable(errrsp_q));

    // R8
    a_r8_en_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~32'h0000_6103) == 32'h0);
endmodule

bind lnk_err_csr lnk_err_csr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_retry_full(ev_retry_full), .irq(irq),
    .gen_q(gen_q), .stat_q(stat_q), .en_q(en_q), .w1c_mask(w1c_mask),
    .errrsp_q(errrsp_q)
);

// File: tb/tb_lnk_err_csr.sv
`timescale 1ns/1ps
module tb_lnk_err_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_seq = '0;
    logic [6:0]  rsp_errstat = '0;
    logic [2:0]  rsp_cub = '0;
    logic        ev_retry_full = 1'b0;
    logic        ev_rspq_ecc = 1'b0;
    logic        fatal_n = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit bseen = 0;
    logic [2:0] bexp = '0;
    logic [31:0] v;

    always #4 clk = ~clk;

    lnk_err_csr dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        csr_addr = a;
        @(negedge clk);
        d = csr_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    // send a response; off is added to the expected tag
    task automatic rsp(input logic [2:0] off, input logic [6:0] es, input logic [2:0] cb);
        rsp_seq = bseen ? bexp + off : 3'd5;
        rsp_valid = 1'b1; rsp_errstat = es; rsp_cub = cb;
        bexp = (bseen ? bexp : rsp_seq) + 3'd1;
        bseen = 1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_errstat = '0;
    endtask

    task automatic fire(input int i);
        case (i)
            0: rsp(3'd3, 7'd0, 3'd0);
            1: rsp(3'd0, 7'h0A, 3'd2);
            2: begin ev_retry_full = 1'b1; @(negedge clk); ev_retry_full = 1'b0; end
            3: begin fatal_n = 1'b0; @(negedge clk); fatal_n = 1'b1; end
            default: begin ev_rspq_ecc = 1'b1; @(negedge clk); ev_rspq_ecc = 1'b0; end
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int bits [5] = '{0, 1, 8, 13, 14};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset values, R1 unmapped read
        rd(4'd8, v);  chk("R2 status reset", v, 32'h0);
        rd(4'd9, v);  chk("R8 enable reset", v, 32'h0);
        rd(4'd10, v); chk("R10 global reset", v, 32'h0);
        rd(4'd5, v);  chk("R5 errrsp reset", v, 32'h0);
        chk("R9 irq reset", {31'b0, irq}, 32'h0);
        wr(4'd9, 32'h0000_0003);
        rd(4'd3, v);  chk("R1 unmapped read", v, 32'h0);
        rd(4'd9, v);  chk("R1 enable readback", v, 32'h3);
        wr(4'd9, 32'h0);

        // R3 continuous count over several wraps
        for (int k = 0; k < 20; k++) rsp(3'd0, 7'd0, 3'd0);
        rd(4'd8, v); chk("R3 in-order no error", v, 32'h0);

        // R3 every nonzero offset, with R2 clear semantics
        for (int d = 1; d < 8; d++) begin
            rsp(3'(d), 7'd0, 3'd0);
            rd(4'd8, v); chk($sformatf("R3 offset %0d", d), v, 32'h1);
            wr(4'd8, 32'hFFFF_FFFE);
            rd(4'd8, v); chk("R2 zero bit keeps", v, 32'h1);
            wr(4'd8, 32'h1);
            rd(4'd8, v); chk("R2 one bit clears", v, 32'h0);
            rsp(3'd0, 7'd0, 3'd0);
            rd(4'd8, v); chk("R3 resumes count", v, 32'h0);
        end

        // R4 / R5
        rsp(3'd0, 7'h25, 3'd3);
        rd(4'd8, v); chk("R4 error response", v, 32'h2);
        rd(4'd5, v); chk("R5 first capture", v, 32'h0000_0325);
        rsp(3'd0, 7'h11, 3'd6);
        rd(4'd5, v); chk("R5 held while set", v, 32'h0000_0325);
        rsp(3'd0, 7'h00, 3'd7);
        rd(4'd5, v); chk("R5 clean rsp ignored", v, 32'h0000_0325);

        // R6 clear and new error in the same cycle
        rsp_seq = bexp; bexp = bexp + 3'd1;
        rsp_valid = 1'b1; rsp_errstat = 7'h7F; rsp_cub = 3'd5;
        csr_addr = 4'd8; csr_wdata = 32'h2; csr_wr = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_errstat = '0; csr_wr = 1'b0;
        rd(4'd8, v); chk("R6 event beats clear", v, 32'h2);
        rd(4'd5, v); chk("R6 new capture", v, 32'h0000_057F);
        wr(4'd8, 32'h2);
        rd(4'd8, v); chk("R2 bit1 cleared", v, 32'h0);
        rsp(3'd0, 7'h01, 3'd0);
        rd(4'd5, v); chk("R5 recapture after clear", v, 32'h0000_0001);
        wr(4'd8, 32'hFFFF_FFFF);

        // R7 event inputs
        fire(2); rd(4'd8, v); chk("R7 retry full", v, 32'h0000_0100);
        wr(4'd8, 32'hFFFF_FFFF);
        fire(4); rd(4'd8, v); chk("R7 rspq ecc", v, 32'h0000_4000);
        wr(4'd8, 32'hFFFF_FFFF);
        fire(3); rd(4'd8, v); chk("R7 fatal pin", v, 32'h0000_2000);
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, v); chk("R2 all cleared", v, 32'h0);

        // R8
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v); chk("R8 enable mask", v, 32'h0000_6103);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, v); chk("R10 global readback", v, 32'h1);
        wr(4'd10, 32'h0);
        wr(4'd9, 32'h0);

        // R9 / R10 per source
        for (int i = 0; i < 5; i++) begin
            logic [31:0] b;
            b = 32'h1 << bits[i];
            wr(4'd9, b);
            wr(4'd10, 32'h1);
            fire(i);
            chk($sformatf("R9 irq not yet src %0d", i), {31'b0, irq}, 32'h0);
            @(negedge clk);
            chk($sformatf("R9 irq src %0d", i), {31'b0, irq}, 32'h1);
            wr(4'd10, 32'h0);
            @(negedge clk);
            chk($sformatf("R10 global off src %0d", i), {31'b0, irq}, 32'h0);
            wr(4'd10, 32'h1);
            @(negedge clk);
            chk($sformatf("R10 global on src %0d", i), {31'b0, irq}, 32'h1);
            wr(4'd9, 32'h0000_6103 & ~b);
            @(negedge clk);
            chk($sformatf("R9 other enables src %0d", i), {31'b0, irq}, 32'h0);
            wr(4'd9, b);
            @(negedge clk);
            wr(4'd8, b);
            @(negedge clk);
            chk($sformatf("R9 irq drops src %0d", i), {31'b0, irq}, 32'h0);
            wr(4'd8, 32'hFFFF_FFFF);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule